// File: doc/BRIEF.md
# Write-Merging Store Buffer

This block sits between a write-through data cache and a slow lower-level memory. Every processor store is handed to it instead of going straight to memory, so the core keeps running. The buffer has a small number of entries. Each entry holds one aligned multi-word block, a block address, and one valid bit per word. A store to a block that already sits in an entry, and that entry is not yet being handed to memory, is written into that entry instead of taking a new one. This is write merging. A `merge_en` input switches merging off, so that every store takes its own entry.

Entries go to memory in the order they were allocated, one at a time, over a request/acknowledge pair. Each request carries the block address, the block data and a per-word enable mask. The oldest entry is offered to memory once one of three things is true: it is completely written, a younger entry exists, or no store is offered in that cycle. From that point the entry is locked until it is acknowledged. The store side stalls only when every entry is occupied and the store cannot merge. The status outputs `buf_level`, `buf_full` and `buf_idle` let a fence or a cache miss wait until the buffer has drained.

Top module: `store_merge_buffer`

## Requirements
- R1: After a synchronous active-low reset, `buf_level` is 0, `buf_idle` is 1, `buf_full` is 0, `st_ready` is 1, and no memory request is raised. A request is never raised while the buffer holds no entry.
- R2: A store with word address A writes its data into word slot A mod 4 of the block whose address is A div 4. On drain, `mem_req_blk` is that block address, and word slot k is presented on `mem_req_data[32k+31:32k]` with enable `mem_req_mask[k]`. Only written words have their mask bit set.
- R3: With `merge_en` high, a store to the block of an occupied, unlocked entry merges into the youngest such entry and leaves `buf_level` unchanged. Sixteen consecutive word stores to four blocks, with memory not acknowledging, occupy exactly 4 entries.
- R4: A merged store to a word that is already valid replaces that word's data. The mask bit stays set.
- R5: With `merge_en` low, every accepted store allocates a new entry, so four stores to one block fill the buffer.
- R6: When all 4 entries are occupied and the store cannot merge, `st_ready` is low and the store is not taken. After an acknowledge frees an entry, the held store is accepted.
- R7: Entries are drained in allocation order, one request per entry.
- R8: Once `mem_req_valid` is high, the request fields and the head entry stay unchanged until `mem_ack`. A store to the head's block then allocates a new entry.
- R9: The oldest entry is first requested in the cycle after any one of these holds: all of its word bits are set, another entry is occupied, or `st_valid` is low. While only one partly written entry exists and stores keep arriving, no request is made.
- R10: `buf_full` is high exactly when `buf_level` is 4. `buf_idle` is high exactly when `buf_level` is 0 and no request is outstanding.
- R11: When the buffer is full, a store that can merge is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| merge_en | input | 1 | 1 enables merging into occupied entries |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | 30 | Word address of the store |
| st_data | input | 32 | Store data |
| mem_req_valid | output | 1 | Oldest entry offered to memory |
| mem_ack | input | 1 | Memory takes the offered entry |
| mem_req_blk | output | 28 | Block address of the offered entry |
| mem_req_mask | output | 4 | Per-word enables of the offered entry |
| mem_req_data | output | 128 | Block data of the offered entry, word k at bits 32k+31:32k |
| buf_level | output | 3 | Number of occupied entries |
| buf_full | output | 1 | All entries occupied |
| buf_idle | output | 1 | No entry and no request outstanding |

## Verification
The bench sweeps every ordered pair of word offsets within one block, with merging both on and off. A design that ORs the mask wrongly, keeps the older value of a twice-written word, or merges while merging is switched off shows a wrong mask, a wrong word or a wrong entry count. A full buffer is probed with a store that cannot merge and one that can. A design that stalls the mergeable store, or accepts the other, shows up through `st_ready` and through the contents drained later. The lock on a request in flight is also tested: a store to the head's block must open a second entry, so a design that merges into the locked head changes `mem_req_mask` while the request is pending. The exact cycle at which the first request is raised is checked as well.

// File: rtl/smb_pkg.sv
// Package smb_pkg
// Shared types and helpers for the write-merging store buffer.
// Assumes the entry count is a power of two and at least two.
package smb_pkg;

    // What the buffer does with the store offered in the current cycle.
    typedef enum logic [1:0] {
        ST_NONE  = 2'd0,
        ST_MERGE = 2'd1,
        ST_ALLOC = 2'd2,
        ST_STALL = 2'd3
    } st_action_t;

    // Age of slot idx relative to the oldest slot head in a ring of n slots.
    function automatic int ring_age(input int idx, input int head, input int n);
        return (idx + n - head) % n;
    endfunction

endpackage

// File: rtl/smb_entry.sv
// Module smb_entry
// One buffer slot: block address, per-word data and per-word valid mask.
// Assumes the controller never allocates a busy slot, never merges into a
// free slot, and never asserts alloc and merge together. Data words are not
// reset; only the mask and busy flag carry meaning after reset.
module smb_entry #(
    parameter int BLK_W  = 28,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_i,
    input  logic                    merge_i,
    input  logic                    free_i,
    input  logic [WORDS-1:0]        word_oh_i,
    input  logic [BLK_W-1:0]        blk_i,
    input  logic [DATA_W-1:0]       data_i,
    output logic                    busy_o,
    output logic [BLK_W-1:0]        blk_o,
    output logic [WORDS-1:0]        mask_o,
    output logic [WORDS*DATA_W-1:0] data_o
);

    logic             busy_q;
    logic [BLK_W-1:0] blk_q;
    logic [WORDS-1:0] mask_q;

    // Occupancy and mask: set on allocation, widened on merge, cleared on free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            mask_q <= '0;
        end else if (free_i) begin
            busy_q <= 1'b0;
            mask_q <= '0;
        end else if (alloc_i) begin
            busy_q <= 1'b1;
            mask_q <= word_oh_i;
        end else if (merge_i) begin
            mask_q <= mask_q | word_oh_i;
        end
    end

    // Block address capture on allocation.
    always_ff @(posedge clk) begin
        if (alloc_i) begin
            blk_q <= blk_i;
        end
    end

    // One data register per word slot, written by alloc or merge.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [DATA_W-1:0] word_q;

        // Word slot write; a repeated write replaces the older value.
        always_ff @(posedge clk) begin
            if ((alloc_i || merge_i) && word_oh_i[w]) begin
                word_q <= data_i;
            end
        end

        assign data_o[w*DATA_W +: DATA_W] = word_q;
    end

    assign busy_o = busy_q;
    assign blk_o  = blk_q;
    assign mask_o = mask_q;

    // A new block only lands in a free slot.
    assert_alloc_into_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> !busy_q);

    // A merge only lands in an occupied slot.
    assert_merge_into_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        merge_i |-> busy_q);

    // An occupied slot always has at least one valid word.
    assert_busy_has_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (mask_q != '0));

endmodule

// File: rtl/smb_match.sv
// Module smb_match
// Finds the youngest occupied slot holding the store's block. It reports a
// hit only when that slot is not the locked head, so that a later write to a
// block can never land in an entry older than another copy of that block.
// Assumes a power-of-two ring of slots, indexed from the oldest slot head_i.
module smb_match #(
    parameter int ENTRIES = 4,
    parameter int BLK_W   = 28,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]       busy_i,
    input  logic [ENTRIES*BLK_W-1:0] blk_flat_i,
    input  logic [BLK_W-1:0]         st_blk_i,
    input  logic [IDX_W-1:0]         head_i,
    input  logic                     lock_i,
    output logic                     hit_o,
    output logic [IDX_W-1:0]         hit_idx_o
);

    logic             found;
    logic [IDX_W-1:0] best_idx;
    int               best_age;

    // Scan all slots and keep the youngest one whose block matches.
    always_comb begin
        found    = 1'b0;
        best_idx = '0;
        best_age = 0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (busy_i[i] && (blk_flat_i[i*BLK_W +: BLK_W] == st_blk_i)) begin
                if (!found || (smb_pkg::ring_age(i, int'(head_i), ENTRIES) > best_age)) begin
                    found    = 1'b1;
                    best_idx = IDX_W'(i);
                    best_age = smb_pkg::ring_age(i, int'(head_i), ENTRIES);
                end
            end
        end
    end

    assign hit_o     = found && !(lock_i && (best_idx == head_i));
    assign hit_idx_o = best_idx;

endmodule

// File: rtl/store_merge_buffer.sv
// Module store_merge_buffer
// Write buffer behind a write-through cache. It merges stores to the same
// aligned block into one entry and drains entries to memory in allocation
// order over a valid/ack pair. The request fields stay unchanged until ack.
// Assumes ENTRIES is a power of two and at least 2, and WORDS is a power of two.
module store_merge_buffer #(
    parameter int ADDR_W  = 30,
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 4,
    parameter int WORDS   = 4,
    localparam int OFF_W  = $clog2(WORDS),
    localparam int BLK_W  = ADDR_W - OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    merge_en,
    input  logic                    st_valid,
    output logic                    st_ready,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [DATA_W-1:0]       st_data,
    output logic                    mem_req_valid,
    input  logic                    mem_ack,
    output logic [BLK_W-1:0]        mem_req_blk,
    output logic [WORDS-1:0]        mem_req_mask,
    output logic [WORDS*DATA_W-1:0] mem_req_data,
    output logic [CNT_W-1:0]        buf_level,
    output logic                    buf_full,
    output logic                    buf_idle
);
    import smb_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ENTRIES);

    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] level_q;
    logic             draining_q;

    logic [BLK_W-1:0]        st_blk;
    logic [OFF_W-1:0]        st_off;
    logic [WORDS-1:0]        word_oh;
    logic                    full;
    logic                    match_hit, merge_hit;
    logic [IDX_W-1:0]        match_idx;
    st_action_t              action;
    logic                    do_merge, do_alloc, drain_done, launch;

    logic [ENTRIES-1:0]       ent_busy;
    logic [ENTRIES*BLK_W-1:0] ent_blk_flat;
    logic [BLK_W-1:0]         ent_blk  [ENTRIES];
    logic [WORDS-1:0]         ent_mask [ENTRIES];
    logic [WORDS*DATA_W-1:0]  ent_data [ENTRIES];

    // Split the word address into block address and word slot.
    assign st_blk  = st_addr[ADDR_W-1:OFF_W];
    assign st_off  = st_addr[OFF_W-1:0];
    assign word_oh = WORDS'(1) << st_off;
    assign full    = (level_q == FULL_CNT);

    smb_match #(
        .ENTRIES (ENTRIES),
        .BLK_W   (BLK_W)
    ) u_match (
        .busy_i     (ent_busy),
        .blk_flat_i (ent_blk_flat),
        .st_blk_i   (st_blk),
        .head_i     (head_q),
        .lock_i     (draining_q),
        .hit_o      (match_hit),
        .hit_idx_o  (match_idx)
    );

    assign merge_hit = merge_en && match_hit;

    // Classify the offered store: merge, allocate, stall or nothing.
    always_comb begin
        if (!st_valid) begin
            action = ST_NONE;
        end else if (merge_hit) begin
            action = ST_MERGE;
        end else if (!full) begin
            action = ST_ALLOC;
        end else begin
            action = ST_STALL;
        end
    end

    assign st_ready   = merge_hit || !full;
    assign do_merge   = (action == ST_MERGE);
    assign do_alloc   = (action == ST_ALLOC);
    assign drain_done = draining_q && mem_ack;

    // Start a drain when the head is complete, has a successor, or stores pause.
    assign launch = !draining_q && (level_q != '0) &&
                    ((ent_mask[head_q] == {WORDS{1'b1}}) || (level_q > CNT_W'(1)) || !st_valid);

    // Slot array: each slot sees its own alloc, merge and free strobes.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        smb_entry #(
            .BLK_W  (BLK_W),
            .DATA_W (DATA_W),
            .WORDS  (WORDS)
        ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_i   (do_alloc && (tail_q == IDX_W'(i))),
            .merge_i   (do_merge && (match_idx == IDX_W'(i))),
            .free_i    (drain_done && (head_q == IDX_W'(i))),
            .word_oh_i (word_oh),
            .blk_i     (st_blk),
            .data_i    (st_data),
            .busy_o    (ent_busy[i]),
            .blk_o     (ent_blk[i]),
            .mask_o    (ent_mask[i]),
            .data_o    (ent_data[i])
        );
        assign ent_blk_flat[i*BLK_W +: BLK_W] = ent_blk[i];
    end

    // Ring pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            level_q <= '0;
        end else begin
            if (drain_done) begin
                head_q <= (head_q == LAST_IDX) ? '0 : head_q + IDX_W'(1);
            end
            if (do_alloc) begin
                tail_q <= (tail_q == LAST_IDX) ? '0 : tail_q + IDX_W'(1);
            end
            level_q <= level_q + CNT_W'(do_alloc) - CNT_W'(drain_done);
        end
    end

    // Drain request flag: raised by launch, dropped on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            draining_q <= 1'b0;
        end else if (launch) begin
            draining_q <= 1'b1;
        end else if (drain_done) begin
            draining_q <= 1'b0;
        end
    end

    assign mem_req_valid = draining_q;
    assign mem_req_blk   = ent_blk[head_q];
    assign mem_req_mask  = ent_mask[head_q];
    assign mem_req_data  = ent_data[head_q];
    assign buf_level     = level_q;
    assign buf_full      = full;
    assign buf_idle      = (level_q == '0) && !draining_q;

    // No request without a stored entry.
    assert_no_req_when_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (buf_level != '0));

    // A pending request holds its fields until acknowledged.
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_ack) |=> (mem_req_valid && $stable(mem_req_blk) &&
                                         $stable(mem_req_mask) && $stable(mem_req_data)));

    // A request always carries at least one enabled word.
    assert_req_has_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_mask != '0));

    // Occupancy never exceeds the slot count.
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_level <= FULL_CNT);

    // A merge with no drain completing leaves the occupancy unchanged.
    assert_merge_keeps_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_merge && !drain_done) |=> $stable(buf_level));

    // The store side stalls only on a full buffer.
    assert_stall_only_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_ready |-> buf_full);

    // The occupied-slot flags agree with the occupancy count.
    assert_busy_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ent_busy) == int'(buf_level));

endmodule

// File: tb/store_merge_buffer_bench.sv
`timescale 1ns/1ps
module store_merge_buffer_bench;
    localparam int ADDR_W = 30;
    localparam int DATA_W = 32;
    localparam int WORDS  = 4;
    localparam int BLK_W  = 28;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    merge_en = 1'b1;
    logic                    st_valid = 1'b0;
    logic                    st_ready;
    logic [ADDR_W-1:0]       st_addr = '0;
    logic [DATA_W-1:0]       st_data = '0;
    logic                    mem_req_valid;
    logic                    mem_ack = 1'b0;
    logic [BLK_W-1:0]        mem_req_blk;
    logic [WORDS-1:0]        mem_req_mask;
    logic [WORDS*DATA_W-1:0] mem_req_data;
    logic [2:0]              buf_level;
    logic                    buf_full;
    logic                    buf_idle;

    int checks = 0;
    int failures = 0;
    bit ack_en = 1'b0;
    int log_n = 0;
    logic [BLK_W-1:0]        log_blk  [64];
    logic [WORDS-1:0]        log_mask [64];
    logic [WORDS*DATA_W-1:0] log_data [64];

    always #10 clk = ~clk;

    store_merge_buffer u_store_merge_buffer (
        .clk (clk), .rst_n (rst_n), .merge_en (merge_en),
        .st_valid (st_valid), .st_ready (st_ready), .st_addr (st_addr), .st_data (st_data),
        .mem_req_valid (mem_req_valid), .mem_ack (mem_ack), .mem_req_blk (mem_req_blk),
        .mem_req_mask (mem_req_mask), .mem_req_data (mem_req_data),
        .buf_level (buf_level), .buf_full (buf_full), .buf_idle (buf_idle)
    );

    // Memory model: acknowledge offered entries and record what was drained.
    initial begin
        forever begin
            @(negedge clk);
            if (ack_en && mem_req_valid) begin
                mem_ack = 1'b1;
                if (log_n < 64) begin
                    log_blk[log_n]  = mem_req_blk;
                    log_mask[log_n] = mem_req_mask;
                    log_data[log_n] = mem_req_data;
                end
                log_n++;
            end else begin
                mem_ack = 1'b0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Offer one store and hold it until taken; returns just after the accepting edge.
    task automatic store(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        st_valid = 1'b1;
        st_addr  = a;
        st_data  = d;
        #1;
        while (!st_ready) begin
            @(posedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        st_valid = 1'b0;
    endtask

    // Let memory acknowledge until the buffer is idle again.
    task automatic drain_all();
        ack_en = 1'b1;
        do begin
            @(posedge clk);
            #1;
        end while (!buf_idle);
        ack_en = 1'b0;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [DATA_W-1:0] word_of(input logic [WORDS*DATA_W-1:0] blk, input int w);
        return blk[w*DATA_W +: DATA_W];
    endfunction

    initial begin
        // Reset state
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        chk("R1", "level after reset", 64'(buf_level), 64'd0);
        chk("R1", "idle after reset", 64'(buf_idle), 64'd1);
        chk("R1", "ready after reset", 64'(st_ready), 64'd1);
        chk("R1", "no request after reset", 64'(mem_req_valid), 64'd0);
        chk("R10", "not full after reset", 64'(buf_full), 64'd0);

        // Sixteen sequential stores with merging and a stalled memory
        merge_en = 1'b1;
        log_n = 0;
        for (int i = 0; i < 16; i++) begin
            store(30'h100 + 30'(i), 32'hA000_0000 + 32'(i));
            if (i == 2) chk("R9", "no request while first entry fills", 64'(mem_req_valid), 64'd0);
        end
        chk("R3", "16 stores occupy 4 entries", 64'(buf_level), 64'd4);
        chk("R10", "full at 4 entries", 64'(buf_full), 64'd1);
        chk("R7", "oldest block offered", 64'(mem_req_blk), 64'h40);
        // A mergeable store into the youngest entry while full
        store(30'h100 + 30'd13, 32'hDEAD_0013);
        chk("R11", "merge accepted when full", 64'(buf_level), 64'd4);
        // A non-mergeable store while full must stall
        st_valid = 1'b1; st_addr = 30'h7000; st_data = 32'h5555_5555;
        #1;
        chk("R6", "ready low when full and no merge", 64'(st_ready), 64'd0);
        repeat (3) @(posedge clk);
        #1;
        chk("R6", "stalled store not taken", 64'(buf_level), 64'd4);
        chk("R6", "still stalled", 64'(st_ready), 64'd0);
        st_valid = 1'b0;
        drain_all();
        chk("R10", "idle after drain", 64'(buf_idle), 64'd1);
        chk("R7", "four drains", 64'(log_n), 64'd4);
        for (int b = 0; b < 4; b++) begin
            chk("R7", "drain order block", 64'(log_blk[b]), 64'(28'h40 + 28'(b)));
            chk("R2", "full mask", 64'(log_mask[b]), 64'hF);
            for (int w = 0; w < 4; w++) begin
                if (b == 3 && w == 1)
                    chk("R4", "overwritten word", 64'(word_of(log_data[b], w)), 64'hDEAD_0013);
                else
                    chk("R2", "word data", 64'(word_of(log_data[b], w)), 64'(32'hA000_0000 + 32'(4*b + w)));
            end
        end

        // Merging off: one entry per store, then stall, then release by ack
        merge_en = 1'b0;
        log_n = 0;
        for (int k = 0; k < 4; k++) begin
            store(30'h400 + 30'(k), 32'hB000_0000 + 32'(k));
            chk("R5", "one entry per store", 64'(buf_level), 64'(k + 1));
        end
        chk("R10", "full after 4 unmerged stores", 64'(buf_full), 64'd1);
        st_valid = 1'b1; st_addr = 30'h400; st_data = 32'hB000_0099;
        #1;
        chk("R6", "same-block store stalls with merge off", 64'(st_ready), 64'd0);
        ack_en = 1'b1;
        store(30'h400, 32'hB000_0099);
        drain_all();
        chk("R6", "stalled store drained after release", 64'(log_n), 64'd5);
        for (int k = 0; k < 5; k++) begin
            chk("R7", "unmerged drain block", 64'(log_blk[k]), 64'h100);
            chk("R5", "single-word mask", 64'(log_mask[k]), 64'(4'(1) << (k % 4)));
            chk("R2", "unmerged word", 64'(word_of(log_data[k], k % 4)),
                64'((k == 4) ? 32'hB000_0099 : 32'hB000_0000 + 32'(k)));
        end

        // Sweep of offset pairs in both modes
        for (int m = 0; m < 2; m++) begin
            merge_en = (m == 1);
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    logic [ADDR_W-1:0] base;
                    logic [DATA_W-1:0] da, db;
                    base = 30'h2000 + 30'((m * 16 + a * 4 + b) * 4);
                    da = 32'hC000_0000 + 32'(m * 256 + a * 16 + b);
                    db = 32'hD000_0000 + 32'(m * 256 + a * 16 + b);
                    log_n = 0;
                    store(base + 30'(a), da);
                    store(base + 30'(b), db);
                    chk(m ? "R3" : "R5", "level after pair", 64'(buf_level), m ? 64'd1 : 64'd2);
                    drain_all();
                    if (m == 1) begin
                        chk("R3", "one merged drain", 64'(log_n), 64'd1);
                        chk("R2", "merged block", 64'(log_blk[0]), 64'(base[ADDR_W-1:2]));
                        chk("R3", "merged mask", 64'(log_mask[0]), 64'((4'(1) << a) | (4'(1) << b)));
                        chk("R4", "second write wins", 64'(word_of(log_data[0], b)), 64'(db));
                        if (a != b) chk("R3", "first word kept", 64'(word_of(log_data[0], a)), 64'(da));
                    end else begin
                        chk("R5", "two drains", 64'(log_n), 64'd2);
                        chk("R5", "first mask", 64'(log_mask[0]), 64'(4'(1) << a));
                        chk("R5", "second mask", 64'(log_mask[1]), 64'(4'(1) << b));
                        chk("R7", "first data", 64'(word_of(log_data[0], a)), 64'(da));
                        chk("R7", "second data", 64'(word_of(log_data[1], b)), 64'(db));
                    end
                end
            end
        end

        // Launch timing and lock of the head in flight
        merge_en = 1'b1;
        log_n = 0;
        store(30'hC00, 32'hE000_0000);
        chk("R9", "no request in accepting cycle", 64'(mem_req_valid), 64'd0);
        @(posedge clk);
        #1;
        chk("R9", "request one cycle after pause", 64'(mem_req_valid), 64'd1);
        chk("R2", "request block", 64'(mem_req_blk), 64'h300);
        chk("R2", "request mask", 64'(mem_req_mask), 64'h1);
        store(30'hC01, 32'hE000_0001);
        chk("R8", "locked head forces new entry", 64'(buf_level), 64'd2);
        chk("R8", "locked mask unchanged", 64'(mem_req_mask), 64'h1);
        drain_all();
        chk("R8", "two drains after lock", 64'(log_n), 64'd2);
        chk("R8", "first drain mask", 64'(log_mask[0]), 64'h1);
        chk("R8", "second drain mask", 64'(log_mask[1]), 64'h2);
        chk("R8", "second drain word", 64'(word_of(log_data[1], 1)), 64'hE000_0001);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule